// File: doc/BRIEF.md
# Layer Descriptor Command Interface

This block sits between a 64-bit register bus and a layer-at-a-time compute engine. Software programs one layer by writing twelve 64-bit descriptor words, one after another, to a single push register. The words are queued in an argument FIFO. A sequencer then collects each complete group of twelve words into one layer command and offers it to the engine over a valid/ready handshake. The engine reports that the layer is finished with a one-cycle done pulse. Only one layer is in flight at any time, so layers run strictly in the order in which they were written.

Whether a layer raises its completion interrupt is decided by flag bit 0 of that layer's own first word. Flag bit 3 of the first word marks a depth-wise layer and is passed to the engine with the command. Interrupt events are gathered in a raw register, which is gated by a mask and cleared by writing ones. The same register set also holds a FIFO level threshold, a flush control and a precision-mode bit that is exported to the engine.

The sequencer has four named states. `SEQ_IDLE` goes to `SEQ_GATHER` when the FIFO holds at least twelve words and no flush is taking place. `SEQ_GATHER` pops one word per cycle into the command register. After the twelfth word it goes to `SEQ_OFFER`, and a flush sends it back to `SEQ_IDLE` with the word index reset. `SEQ_OFFER` raises the command valid and moves to `SEQ_RUN` on ready. `SEQ_RUN` waits for the done pulse and then returns to `SEQ_IDLE`. A flush leaves a command that has already been collected untouched.

Top module: `layer_cmd_if`

## Requirements
- R1: After reset, cmd_valid, irq and eight_bit_mode are 0, and the raw, mask, threshold and precision registers read 0.
- R2: The register offsets are: 0x00 descriptor push, 0x08 status, 0x10 raw, 0x18 mask (bits 2:0), 0x20 clear, 0x28 threshold, 0x30 data-out, 0x38 flush, 0x40 precision (bit 0). The mask, threshold and precision registers read back what was written. Precision bit 0 drives eight_bit_mode.
- R3: A command is offered only once all twelve words of a descriptor have been written. Descriptor word k appears on cmd_words[64k+63:64k], with the words in the order they were written.
- R4: While cmd_valid is high and cmd_ready is low, the command stays valid and unchanged. The next command is not offered until layer_done has been received for the accepted one.
- R5: cmd_irq_req equals bit 0 of word 0 of the current command, and cmd_depthwise equals bit 3 of word 0.
- R6: layer_done sets raw bit 0 only when the running layer's word 0 bit 0 is 1. A layer_done pulse while no layer is running has no effect.
- R7: The argument FIFO holds 32 words. A push while the FIFO is full is dropped and sets raw bit 2.
- R8: Writing 1 to bit 0 of the flush register empties the FIFO and aborts a partly collected command. The next twelve words pushed form the next command.
- R9: Raw bit 1 is set when the FIFO occupancy falls from above the threshold to at or below it.
- R10: Status reads raw AND mask. irq is high exactly when some status bit is 1.
- R11: Writing the clear register clears the raw bits written as 1 and leaves the other bits unchanged.
- R12: Reads of offsets 0x00, 0x20, 0x30 and 0x38 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data (combinational from bus_addr) |
| cmd_valid | output | 1 | Layer command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_words | output | 768 | Twelve descriptor words, word k at [64k+63:64k] |
| cmd_irq_req | output | 1 | The layer requests a completion interrupt |
| cmd_depthwise | output | 1 | Depth-wise layer flag |
| layer_done | input | 1 | Pulse: the running layer has finished |
| eight_bit_mode | output | 1 | Selects 8-bit precision instead of 16-bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes eleven words and then waits. A design that counted badly, or that offered a command on a partial descriptor, would raise cmd_valid before the twelfth word arrives. Two descriptors are queued back to back. A design that did not wait for the done pulse would offer the second command while the first is still running. The bench fills the FIFO to exactly 44 accepted words (32 in the FIFO and 12 held in the command) before one extra push. An off-by-one in the full check would flag overflow too early or lose a queued word. A flush is issued in the middle of collection, and a second flush after a partial push. A sequencer that kept its word index would then build a command from misaligned words. Interrupt checks cover a done pulse while no layer is running, and a layer without the request flag. The masking of the raw register and selective write-one-to-clear are checked as well.

// File: rtl/lcmd_pkg.sv
package lcmd_pkg;
    localparam int WORD_W     = 64;
    localparam int DESC_WORDS = 12;

    localparam logic [6:0] A_ARG    = 7'h00;
    localparam logic [6:0] A_STATUS = 7'h08;
    localparam logic [6:0] A_RAW    = 7'h10;
    localparam logic [6:0] A_MASK   = 7'h18;
    localparam logic [6:0] A_CLEAR  = 7'h20;
    localparam logic [6:0] A_THRESH = 7'h28;
    localparam logic [6:0] A_DOUT   = 7'h30;
    localparam logic [6:0] A_FLUSH  = 7'h38;
    localparam logic [6:0] A_PREC   = 7'h40;

    localparam int IRQ_DONE  = 0;
    localparam int IRQ_LEVEL = 1;
    localparam int IRQ_OVF   = 2;
    localparam int IRQ_N     = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_GATHER,
        SEQ_OFFER,
        SEQ_RUN
    } seq_state_e;
endpackage

// File: rtl/lcmd_fifo.sv
module lcmd_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/lcmd_seq.sv
module lcmd_seq
    import lcmd_pkg::*;
#(
    parameter int W     = 64,
    parameter int NW    = 12,
    parameter int CNT_W = 6,
    localparam int IW   = $clog2(NW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic [W-1:0]    fifo_rdata,
    output logic            fifo_pop,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [NW*W-1:0] cmd_words,
    output logic            cmd_irq_req,
    output logic            cmd_depthwise,
    input  logic            layer_done,
    output logic            done_evt
);
    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  words_q [NW];
    logic          gather_last;

    assign gather_last = (idx_q == IW'(NW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (!flush && fifo_cnt >= CNT_W'(NW)) state_d = SEQ_GATHER;
            SEQ_GATHER: if (flush)             state_d = SEQ_IDLE;
                        else if (gather_last)  state_d = SEQ_OFFER;
            SEQ_OFFER:  if (cmd_ready)         state_d = SEQ_RUN;
            SEQ_RUN:    if (layer_done)        state_d = SEQ_IDLE;
            default:                           state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        fifo_pop  = (state_q == SEQ_GATHER) && !flush;
        cmd_valid = (state_q == SEQ_OFFER);
        done_evt  = (state_q == SEQ_RUN) && layer_done && words_q[0][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              idx_q <= '0;
        else if (state_q != SEQ_GATHER || flush) idx_q <= '0;
        else                                     idx_q <= gather_last ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) words_q[i] <= '0;
        end else if (fifo_pop) begin
            words_q[idx_q] <= fifo_rdata;
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_flat
        assign cmd_words[g*W +: W] = words_q[g];
    end

    assign cmd_irq_req   = words_q[0][0];
    assign cmd_depthwise = words_q[0][3];
endmodule

// File: rtl/lcmd_irq.sv
module lcmd_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_vec,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_vec,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (clr_wr ? (raw & ~clr_vec) : raw) | set_vec;
            if (mask_wr) mask <= mask_vec;
        end
    end

    assign status = raw & mask;
    assign irq    = |status;
endmodule

// File: rtl/layer_cmd_if.sv
module layer_cmd_if
    import lcmd_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int NW    = DESC_WORDS,
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [6:0]      bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [NW*W-1:0] cmd_words,
    output logic            cmd_irq_req,
    output logic            cmd_depthwise,
    input  logic            layer_done,
    output logic            eight_bit_mode,
    output logic            irq
);
    logic          wr_arg, flush, fifo_pop, fifo_full, done_evt, level_evt, ovf_evt;
    logic [W-1:0]  fifo_rdata;
    logic [CW-1:0] fifo_cnt, cnt_prev_q, thr_q;
    logic          prec_q;
    logic [IRQ_N-1:0] raw_q, mask_q, status;
    logic [IRQ_N-1:0] set_vec;

    assign wr_arg    = bus_wr && (bus_addr == A_ARG);
    assign flush     = bus_wr && (bus_addr == A_FLUSH) && bus_wdata[0];
    assign ovf_evt   = wr_arg && fifo_full;
    assign level_evt = (cnt_prev_q > thr_q) && (fifo_cnt <= thr_q);

    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_DONE]  = done_evt;
        set_vec[IRQ_LEVEL] = level_evt;
        set_vec[IRQ_OVF]   = ovf_evt;
    end

    lcmd_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr_arg), .wdata(bus_wdata),
        .pop(fifo_pop), .rdata(fifo_rdata),
        .count(fifo_cnt), .full(fifo_full)
    );

    lcmd_seq #(.W(W), .NW(NW), .CNT_W(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fifo_cnt(fifo_cnt), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_words(cmd_words),
        .cmd_irq_req(cmd_irq_req), .cmd_depthwise(cmd_depthwise),
        .layer_done(layer_done), .done_evt(done_evt)
    );

    lcmd_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_wr(bus_wr && bus_addr == A_CLEAR), .clr_vec(bus_wdata[IRQ_N-1:0]),
        .mask_wr(bus_wr && bus_addr == A_MASK), .mask_vec(bus_wdata[IRQ_N-1:0]),
        .raw(raw_q), .mask(mask_q), .status(status), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q      <= '0;
            prec_q     <= 1'b0;
            cnt_prev_q <= '0;
        end else begin
            cnt_prev_q <= fifo_cnt;
            if (bus_wr && bus_addr == A_THRESH) thr_q  <= bus_wdata[CW-1:0];
            if (bus_wr && bus_addr == A_PREC)   prec_q <= bus_wdata[0];
        end
    end

    assign eight_bit_mode = prec_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: bus_rdata[IRQ_N-1:0] = status;
            A_RAW:    bus_rdata[IRQ_N-1:0] = raw_q;
            A_MASK:   bus_rdata[IRQ_N-1:0] = mask_q;
            A_THRESH: bus_rdata[CW-1:0]    = thr_q;
            A_PREC:   bus_rdata[0]         = prec_q;
            default:  bus_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/lcmd_checker.sv
module lcmd_checker #(
    parameter int W     = 64,
    parameter int NW    = 12,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [NW*W-1:0] cmd_words,
    input logic [CW-1:0]   fifo_cnt,
    input logic            fifo_full,
    input logic            wr_arg,
    input logic            flush,
    input logic            done_evt,
    input logic [2:0]      raw_q,
    input logic [2:0]      mask_q,
    input logic            irq
);
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_words)); // R4
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arg && fifo_full |=> raw_q[2] && $stable(fifo_cnt) || raw_q[2]); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fifo_cnt == '0); // R8
    AST_DONE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> raw_q[0]); // R6
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == 3'b000 |-> !irq); // R10
endmodule

bind layer_cmd_if lcmd_checker #(.W(W), .NW(NW), .DEPTH(DEPTH), .CW(CW)) u_lcmd_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_words(cmd_words), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full),
    .wr_arg(wr_arg), .flush(flush), .done_evt(done_evt),
    .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/test_layer_cmd_if.sv
module test_layer_cmd_if;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 64;
    localparam int NW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [6:0]      bus_addr = '0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic            cmd_valid;
    logic            cmd_ready = 1'b0;
    logic [NW*W-1:0] cmd_words;
    logic            cmd_irq_req, cmd_depthwise;
    logic            layer_done = 1'b0;
    logic            eight_bit_mode, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    layer_cmd_if i_layer_cmd_if (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_words(cmd_words),
        .cmd_irq_req(cmd_irq_req), .cmd_depthwise(cmd_depthwise),
        .layer_done(layer_done), .eight_bit_mode(eight_bit_mode), .irq(irq)
    );

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] dword(input logic [15:0] seed, input int k, input logic [3:0] flags);
        logic [63:0] v;
        v = {seed, 16'h5A00 + 16'(k), 16'(k) * 16'h0101, 16'h0};
        if (k == 0) v[3:0] = flags;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; cmd_ready = 1'b0; layer_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [63:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic push_words(input logic [15:0] seed, input logic [3:0] flags, input int first, input int n);
        for (int k = first; k < first + n; k++) bus_write(7'h00, dword(seed, k, flags));
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
    endtask

    task automatic accept();
        wait_valid();
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic pulse_done();
        layer_done = 1'b1;
        @(negedge clk);
        layer_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_cmd(input string req, input logic [15:0] seed, input logic [3:0] flags);
        int bad;
        bad = -1;
        for (int k = NW - 1; k >= 0; k--)
            if (cmd_words[k*W +: W] !== dword(seed, k, flags)) bad = k;
        if (bad < 0) check_eq(req, 64'd0, 64'd0);
        else check_eq({req, " word"}, cmd_words[bad*W +: W], dword(seed, bad, flags));
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check_eq("R1 cmd_valid", 64'(cmd_valid), 64'd0);
        check_eq("R1 irq", 64'(irq), 64'd0);
        check_eq("R1 eight_bit_mode", 64'(eight_bit_mode), 64'd0);
        bus_read(7'h10, d); check_eq("R1 raw", d, 64'd0);
        bus_read(7'h18, d); check_eq("R1 mask", d, 64'd0);
        bus_read(7'h28, d); check_eq("R1 threshold", d, 64'd0);
        bus_read(7'h40, d); check_eq("R1 precision", d, 64'd0);
    endtask

    task automatic t_regs();
        logic [63:0] d;
        bus_write(7'h18, 64'h5); bus_read(7'h18, d); check_eq("R2 mask readback", d, 64'h5);
        bus_write(7'h28, 64'h7); bus_read(7'h28, d); check_eq("R2 threshold readback", d, 64'h7);
        bus_write(7'h40, 64'h1); bus_read(7'h40, d); check_eq("R2 precision readback", d, 64'h1);
        check_eq("R2 eight_bit_mode port", 64'(eight_bit_mode), 64'd1);
        bus_read(7'h00, d); check_eq("R12 push offset reads 0", d, 64'd0);
        bus_read(7'h20, d); check_eq("R12 clear offset reads 0", d, 64'd0);
        bus_read(7'h30, d); check_eq("R12 data-out offset reads 0", d, 64'd0);
        bus_read(7'h38, d); check_eq("R12 flush offset reads 0", d, 64'd0);
    endtask

    task automatic t_partial();
        do_reset();
        push_words(16'h1111, 4'b1001, 0, 11);
        repeat (30) @(negedge clk);
        check_eq("R3 no command on 11 words", 64'(cmd_valid), 64'd0);
        push_words(16'h1111, 4'b1001, 11, 1);
        wait_valid();
        check_eq("R3 command after 12 words", 64'(cmd_valid), 64'd1);
        check_cmd("R3 word order", 16'h1111, 4'b1001);
        check_eq("R5 irq request flag", 64'(cmd_irq_req), 64'd1);
        check_eq("R5 depth-wise flag", 64'(cmd_depthwise), 64'd1);
    endtask

    task automatic t_order();
        do_reset();
        push_words(16'hAAAA, 4'b0000, 0, NW);
        push_words(16'hBBBB, 4'b1000, 0, NW);
        wait_valid();
        check_cmd("R3 first command", 16'hAAAA, 4'b0000);
        repeat (5) @(negedge clk);
        check_eq("R4 held while not ready", 64'(cmd_valid), 64'd1);
        check_cmd("R4 stable while not ready", 16'hAAAA, 4'b0000);
        accept();
        repeat (30) @(negedge clk);
        check_eq("R4 no second command before done", 64'(cmd_valid), 64'd0);
        pulse_done();
        wait_valid();
        check_cmd("R4 second command in order", 16'hBBBB, 4'b1000);
        check_eq("R5 depth-wise flag", 64'(cmd_depthwise), 64'd1);
        check_eq("R5 irq request flag", 64'(cmd_irq_req), 64'd0);
    endtask

    task automatic t_done_irq();
        logic [63:0] d;
        do_reset();
        bus_write(7'h18, 64'h1);
        pulse_done();
        bus_read(7'h10, d); check_eq("R6 done while idle ignored", d & 64'h1, 64'd0);
        push_words(16'hC0C0, 4'b0001, 0, NW);
        accept();
        pulse_done();
        bus_read(7'h10, d); check_eq("R6 done with request", d & 64'h1, 64'h1);
        bus_read(7'h08, d); check_eq("R10 status is raw and mask", d, 64'h1);
        check_eq("R10 irq high", 64'(irq), 64'd1);
        bus_write(7'h20, 64'h1);
        bus_read(7'h10, d); check_eq("R11 clear done bit", d & 64'h1, 64'd0);
        check_eq("R10 irq low after clear", 64'(irq), 64'd0);
        push_words(16'hC1C1, 4'b0000, 0, NW);
        accept();
        pulse_done();
        bus_read(7'h10, d); check_eq("R6 done without request", d & 64'h1, 64'd0);
    endtask

    task automatic t_overflow();
        logic [63:0] d;
        do_reset();
        push_words(16'hD0D0, 4'b0000, 0, 44);
        repeat (5) @(negedge clk);
        bus_read(7'h10, d); check_eq("R7 no overflow at 44 words", d & 64'h4, 64'd0);
        push_words(16'hD0D0, 4'b0000, 44, 1);
        bus_read(7'h10, d); check_eq("R7 overflow on full push", d, 64'h4);
        bus_read(7'h08, d); check_eq("R10 status masked", d, 64'd0);
        check_eq("R10 irq masked", 64'(irq), 64'd0);
        bus_write(7'h20, 64'h2);
        bus_read(7'h10, d); check_eq("R11 other bits kept", d, 64'h4);
        bus_write(7'h20, 64'h4);
        bus_read(7'h10, d); check_eq("R11 overflow cleared", d, 64'd0);
        accept();
        pulse_done();
        wait_valid();
        check_eq("R7 queued word 12 kept", cmd_words[0 +: W], dword(16'hD0D0, 12, 4'b0000));
        check_eq("R7 queued word 23 kept", cmd_words[11*W +: W], dword(16'hD0D0, 23, 4'b0000));
    endtask

    task automatic t_flush();
        do_reset();
        push_words(16'hE0E0, 4'b0000, 0, NW);
        repeat (3) @(negedge clk);
        bus_write(7'h38, 64'h1);
        push_words(16'hE1E1, 4'b0001, 0, NW);
        wait_valid();
        check_cmd("R8 flush during collection", 16'hE1E1, 4'b0001);
        accept();
        pulse_done();
        push_words(16'hE2E2, 4'b0000, 0, 5);
        bus_write(7'h38, 64'h1);
        push_words(16'hE3E3, 4'b1000, 0, NW);
        wait_valid();
        check_cmd("R8 flush restarts word count", 16'hE3E3, 4'b1000);
    endtask

    task automatic t_thresh();
        logic [63:0] d;
        do_reset();
        bus_write(7'h28, 64'd3);
        push_words(16'hF0F0, 4'b0000, 0, 2);
        repeat (5) @(negedge clk);
        bus_read(7'h10, d); check_eq("R9 no event from below", d & 64'h2, 64'd0);
        push_words(16'hF0F0, 4'b0000, 2, 10);
        wait_valid();
        repeat (2) @(negedge clk);
        bus_read(7'h10, d); check_eq("R9 event on falling to threshold", d & 64'h2, 64'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_regs();
        t_partial();
        t_order();
        t_done_irq();
        t_overflow();
        t_flush();
        t_thresh();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule